// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Register

This block is the interrupt status and enable register of a clock controller. Six clock sources report readiness to it: an internal high-speed oscillator, an external high-speed oscillator, an internal low-speed oscillator, an external low-speed oscillator, a main PLL and an audio PLL. A clock-failure detector for the external high-speed oscillator reports to it as well. The block turns rising edges on these inputs into sticky flags. Software sets an enable bit to arm each ready flag. A flag is cleared only by writing 1 to its own clear bit, and the block drives one combined interrupt line.

Software reaches the block through a single 32-bit register on a simple bus. A write updates every enable bit and applies any clear bits at the same moment. Reads are combinational. The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `clk_ready_irq_ctrl`

## Requirements
- R1: After reset, every flag and every enable reads 0 and `irq_o` is 0.
- R2: Source i has `rdy_i[i]` with i=0 internal low-speed, 1 external low-speed, 2 internal high-speed, 3 external high-speed, 4 main PLL, 5 audio PLL. A rising edge on `rdy_i[i]`, sampled while enable bit 8+i holds 1, sets flag bit i one clock later.
- R3: A ready flag is not set by a rising edge that meets a 0 enable. This includes an edge in the same clock as the write that sets the enable. A level that stays high sets nothing further.
- R4: A rising edge on `fail_det_i` sets flag bit 7 one clock later, whatever the enables hold.
- R5: A write with bit 16+i at 1 clears ready flag i, and a write with bit 23 at 1 clears the failure flag. A 0 in a clear bit leaves its flag unchanged.
- R6: When a set event and a clear of the same flag arrive in the same clock, the flag ends up at 1.
- R7: Enable bits 8 to 13 take the written value on every write and read back unchanged. Clearing an enable leaves an already latched flag at 1.
- R8: Writes to bits 0 to 7 have no effect. Bit 6, bits 14 and 15, and bits 16 to 31 always read as 0.
- R9: `irq_o` is the OR of flag bits 0 to 7. It stays at 1 until every set flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rdy_i | input | 6 | Ready levels of the six clock sources |
| fail_det_i | input | 1 | External high-speed clock failure detect |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check several properties. A set event always leaves its flag at 1, so set wins over clear. A clear that meets no set leaves the flag at 0. An edge that meets a 0 enable sets nothing. A failure edge always latches. The enables change only on writes, reserved bits read 0, and the interrupt line holds until a clear write arrives. Other behaviour shows only in the bench scenarios. These cover the exact mapping of sources to bit positions across all 64 enable patterns, the arithmetic of many clear masks against latched flags, and the edge-only rule under a held level. They also cover an enable written in the same clock as an edge, and writes to the flag bits having no effect.

// File: rtl/clkint_pkg.sv
package clkint_pkg;
  localparam int unsigned NSRC     = 6;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned RSVD_BIT = NSRC;
  localparam int unsigned FAIL_BIT = NSRC + 1;
  localparam int unsigned FLAG_W   = NSRC + 2;
  localparam int unsigned EN_LSB   = FLAG_W;
  localparam int unsigned CLR_LSB  = 16;
  localparam int unsigned RST_STG  = 2;
endpackage

// File: rtl/clkint_rst_sync.sv
module clkint_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clkint_edge_det.sv
module clkint_edge_det #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end
endmodule

// File: rtl/clkint_flag_cell.sv
module clkint_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/clk_ready_irq_ctrl.sv
module clk_ready_irq_ctrl
  import clkint_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  rdy_i,
  input  logic             fail_det_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int unsigned NIN = NSRC + 1;

  logic              rst_n;
  logic [NIN-1:0]    rise;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   en_d;
  logic              en_ce;
  logic [NSRC-1:0]   rdy_set;
  logic [NSRC-1:0]   rdy_clr;
  logic [NSRC-1:0]   rdy_flag;
  logic              fail_set;
  logic              fail_clr;
  logic              fail_flag;
  logic [FLAG_W-1:0] flags;
  logic              any_clr;
  logic              unused_wdata;

  clkint_rst_sync #(.STAGES(RST_STG)) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  clkint_edge_det #(.W(NIN)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_i  ({fail_det_i, rdy_i}),
    .rise_o (rise)
  );

  // enable register: written whole on every bus write
  always_comb begin
    en_ce = wr_en_i;
    en_d  = wdata_i[EN_LSB +: NSRC];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // set and clear requests
  always_comb begin
    rdy_set  = rise[NSRC-1:0] & en_q;
    rdy_clr  = {NSRC{wr_en_i}} & wdata_i[CLR_LSB +: NSRC];
    fail_set = rise[NSRC];
    fail_clr = wr_en_i & wdata_i[CLR_LSB + FAIL_BIT];
    any_clr  = (|rdy_clr) | fail_clr;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_rdy
    clkint_flag_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .set_i  (rdy_set[g]),
      .clr_i  (rdy_clr[g]),
      .flag_o (rdy_flag[g])
    );

    p_no_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      (!en_q[g] && !rdy_flag[g]) |=> !rdy_flag[g]);
  end

  clkint_flag_cell i_fail_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (fail_set),
    .clr_i  (fail_clr),
    .flag_o (fail_flag)
  );

  always_comb begin
    flags           = '0;
    flags[NSRC-1:0] = rdy_flag;
    flags[FAIL_BIT] = fail_flag;
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[FLAG_W-1:0]       = flags;
    rdata_o[EN_LSB +: NSRC]   = en_q;
  end

  assign irq_o = |flags;

  assign unused_wdata = ^{wdata_i[FLAG_W-1:0],
                          wdata_i[CLR_LSB-1:EN_LSB+NSRC],
                          wdata_i[CLR_LSB+RSVD_BIT],
                          wdata_i[REG_W-1:CLR_LSB+FLAG_W]};

  p_fail_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(fail_det_i) |=> rdata_o[FAIL_BIT]);
  p_en_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_i |=> $stable(rdata_o[EN_LSB +: NSRC]));
  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rdata_o[RSVD_BIT] == 1'b0) && (rdata_o[REG_W-1:EN_LSB+NSRC] == '0));
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !any_clr) |=> irq_o);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_n |-> (rdata_o == '0 && !irq_o));
endmodule

// File: tb/test_clk_ready_irq_ctrl.sv
`timescale 1ns/1ps
module test_clk_ready_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  rdy;
  logic        fail;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  clk_ready_irq_ctrl i_clk_ready_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rdy_i(rdy), .fail_det_i(fail),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic drive(logic [5:0] r, logic f);
    @(negedge clk); rdy = r; fail = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rdy = '0; fail = 1'b0; wr_en = 1'b0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // per source, armed and unarmed
    for (int i = 0; i < 6; i++) begin
      for (int e = 0; e < 2; e++) begin
        wr(32'(e) << (8 + i));
        chk("R7 enable readback", {26'h0, rdata[13:8]}, 32'(e) << i);
        drive(6'(1 << i), 1'b0);
        chk(e ? "R2 armed source" : "R3 unarmed source",
            {24'h0, rdata[7:0]}, e ? (32'h1 << i) : 32'h0);
        chk("R9 irq", {31'h0, irq}, 32'(e));
        drive('0, 1'b0);
        wr(32'h00FF_0000);
        chk("R5 clear all", {24'h0, rdata[7:0]}, 32'h0);
      end
    end

    // all 64 enable patterns, then a clear mask per pattern
    for (int p = 0; p < 64; p++) begin
      int m;
      m = (p * 5 + 3) & 63;
      wr(32'(p) << 8);
      drive(6'h3F, 1'b0);
      chk("R2 enable pattern", {24'h0, rdata[7:0]}, 32'(p));
      drive('0, 1'b0);
      wr((32'(m) << 16) | (32'(p) << 8));
      chk("R5 clear mask", {24'h0, rdata[7:0]}, 32'(p & ~m & 63));
      wr(32'h00FF_0000);
    end

    // level held: no second set
    wr(32'h0000_3F00);
    drive(6'h3F, 1'b0);
    wr(32'h00FF_3F00);
    repeat (3) @(negedge clk);
    chk("R3 level only", {24'h0, rdata[7:0]}, 32'h0);

    // enable cleared keeps the latched flag
    drive('0, 1'b0);
    drive(6'h10, 1'b0);
    wr(32'h0);
    chk("R7 flag kept", {24'h0, rdata[7:0]}, 32'h10);
    wr(32'h00FF_0000);

    // failure flag needs no enable
    drive('0, 1'b1);
    chk("R4 failure flag", {24'h0, rdata[7:0]}, 32'h80);
    chk("R9 irq failure", {31'h0, irq}, 32'h1);
    wr(32'h0080_0000);
    chk("R5 failure clear", {24'h0, rdata[7:0]}, 32'h0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    drive('0, 1'b0);

    // set beats clear in the same clock
    wr(32'h0000_0400);
    @(negedge clk); rdy = 6'h04; fail = 1'b1; wr_en = 1'b1; wdata = 32'h0084_0400;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    chk("R6 set wins", {24'h0, rdata[7:0]}, 32'h84);
    drive('0, 1'b0);
    wr(32'h00FF_0000);

    // enable written in the same clock as the edge
    @(negedge clk); rdy = 6'h08; wr_en = 1'b1; wdata = 32'h0000_0800;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    chk("R3 same-clock enable", {24'h0, rdata[7:0]}, 32'h0);
    drive('0, 1'b0);

    // low-byte writes ignored, reserved bits zero
    wr(32'h0000_0200);
    drive(6'h02, 1'b0);
    wr(32'h0000_02FF);
    chk("R8 flag write ignored", {24'h0, rdata[7:0]}, 32'h02);
    wr(32'h0000_0200);
    chk("R8 zero write ignored", {24'h0, rdata[7:0]}, 32'h02);
    wr(32'hFF00_C040);
    chk("R8 reserved zero", rdata & 32'hFFFF_C040, 32'h0);
    drive('0, 1'b0);
    wr(32'h00FF_0000);

    // irq holds until the last flag goes
    wr(32'h0000_1100);
    drive(6'h11, 1'b0);
    wr(32'h0001_0000);
    chk("R9 irq still high", {31'h0, irq}, 32'h1);
    wr(32'h0010_0000);
    chk("R9 irq released", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule